// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether conditional branches will be taken. It keeps three tables of one-bit entries. The address table is indexed by the branch address alone. The pattern table is indexed by the branch address XORed with a speculative global history of recent outcomes. The chooser table uses the same index as the pattern table and decides which of the two guesses is reported. Several branches from one fetch group can be looked up in the same cycle, two by default, on parallel lanes. Each lane returns its guess and the history value it used. The fetch side keeps that history value with the branch as a checkpoint.

When a branch resolves, the execution side sends back the branch address, the checkpoint, the real outcome and a mispredict flag. The entry in the address table and the entry in the pattern table both take the real outcome. The chooser entry changes only when the two tables disagreed, and it then points at the table that was right. The speculative history shifts in every guess it issues. After a mispredict it is rebuilt from the checkpoint with the real outcome appended.

After reset a two-state controller (CLEAR, RUN) sweeps every table entry to zero, one index per cycle. The block then accepts traffic. There is one transition, CLEAR to RUN, taken on the cycle the sweep writes the last index. RUN is permanent until the next reset.

Top module: `tbp_tournament`

## Requirements
- R1: After reset is released, `pred_ready` is low for exactly 2^IDX_W rising clock edges. It then rises and stays high until the next reset.
- R2: While `pred_ready` is low, every bit of `lk_taken` is 0. Updates are ignored and lookups do not shift the history. The first lookup after `pred_ready` rises therefore sees a history of all zeros and tables that have not been written.
- R3: Once `pred_ready` is high and before any update, every table entry is 0. Every lookup returns not-taken.
- R4: A valid lane reads address-table entry `a` (its `lk_addr` slice) and pattern-table and chooser entries `a ^ h`, where `h` is the lane's history zero-extended to IDX_W. It reports the pattern-table bit when the chooser bit is 1 and the address-table bit when the chooser bit is 0. An invalid lane reports 0.
- R5: An update with `up_valid` high writes `up_taken` into address-table entry `up_addr` and into pattern-table entry `up_addr ^ up_hist`.
- R6: An update changes chooser entry `up_addr ^ up_hist` only when the address-table and pattern-table entries it trains held different values before the update. The entry becomes 1 if the pattern-table value equalled `up_taken`, and 0 otherwise.
- R7: Lane 0 reports the speculative history as its `lk_hist` slice. Each higher lane reports the history after the lower valid lanes have shifted in their guesses. A shift moves the history one place toward the MSB and puts the guess in bit 0. With no restore, the register takes the history that results after all valid lanes have shifted.
- R8: An update with `up_mispred` high sets the speculative history to `{up_hist[HIST_W-2:0], up_taken}`. This overrides any shifting from lookups in the same cycle.
- R9: A lookup in the same cycle as an update to the entries it reads sees the contents from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | LANES | Lane i carries a branch to predict |
| lk_addr | input | LANES*IDX_W | Branch index bits per lane, lane i at [i*IDX_W +: IDX_W] |
| lk_taken | output | LANES | Guess per lane, 1 = taken |
| lk_hist | output | LANES*HIST_W | History used by lane i, at [i*HIST_W +: HIST_W]; kept as checkpoint |
| up_valid | input | 1 | A resolved branch is reported |
| up_addr | input | IDX_W | Index bits of the resolved branch |
| up_hist | input | HIST_W | Checkpoint returned with the resolved branch |
| up_taken | input | 1 | Real outcome, 1 = taken |
| up_mispred | input | 1 | The earlier guess was wrong; restore the history |
| pred_ready | output | 1 | High once the clearing sweep has finished |

## Verification
The bench runs a configuration with 16-entry tables and a 4-bit history. It holds its own model of the three tables and the history register. First, the bench sweeps every address with no training, which shows any entry the clearing pass did not zero. It then trains every address with agreeing outcomes, which tests the address and pattern tables without touching the chooser. Long pseudo-random streams follow, with one lane, both lanes or no lane active, random checkpoints, and mispredicts on or off. These create disagreements between the tables, so they tell apart the chooser policy, the lane-to-lane history chaining and the restore priority. A final phase aims an update at exactly the entry a lookup reads in the same cycle, to separate old-value from new-value reads.

// File: rtl/tbp_pkg.sv
package tbp_pkg;
    // Controller states: CLEAR sweeps all table entries to zero, RUN serves traffic.
    typedef enum logic [0:0] {
        ST_CLEAR = 1'b0,
        ST_RUN   = 1'b1
    } tbp_state_e;
endpackage

// File: rtl/tbp_table.sv
// One-bit-per-entry prediction table: a single write port, full contents visible for reads.
module tbp_table #(
    parameter int IDX_W = 11
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [IDX_W-1:0]        waddr,
    input  logic                    wdata,
    output logic [(1<<IDX_W)-1:0]   bits_q
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0] store_q;

    always_ff @(posedge clk) begin
        if (we) begin
            store_q[waddr] <= wdata;
        end
    end

    assign bits_q = store_q;

    // R5
    wr_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (bits_q[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/tbp_hist.sv
// Speculative global history register with checkpoint restore.
module tbp_hist #(
    parameter int HIST_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restore,
    input  logic [HIST_W-1:0] restore_val,
    input  logic [HIST_W-1:0] shift_val,
    output logic [HIST_W-1:0] hist_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (restore) begin
            hist_q <= restore_val;
        end else begin
            hist_q <= shift_val;
        end
    end
endmodule

// File: rtl/tbp_tournament.sv
module tbp_tournament
    import tbp_pkg::*;
#(
    parameter int LANES  = 2,
    parameter int IDX_W  = 11,
    parameter int HIST_W = 11
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [LANES-1:0]         lk_valid,
    input  logic [LANES*IDX_W-1:0]   lk_addr,
    output logic [LANES-1:0]         lk_taken,
    output logic [LANES*HIST_W-1:0]  lk_hist,
    input  logic                     up_valid,
    input  logic [IDX_W-1:0]         up_addr,
    input  logic [HIST_W-1:0]        up_hist,
    input  logic                     up_taken,
    input  logic                     up_mispred,
    output logic                     pred_ready
);
    localparam int DEPTH = 1 << IDX_W;

    tbp_state_e         st_q, st_d;
    logic [IDX_W-1:0]   clr_q;

    logic [DEPTH-1:0]   loc_bits, pat_bits, sel_bits;
    logic               we_loc, we_pat, we_sel;
    logic [IDX_W-1:0]   a_loc, a_pat;
    logic               d_loc, d_pat, d_sel;

    logic [HIST_W-1:0]  spec_q;
    logic [HIST_W-1:0]  spec_shift;
    logic [HIST_W-1:0]  spec_restore;

    logic               upd;
    logic [IDX_W-1:0]   u_lidx, u_gidx;
    logic               u_l, u_g;

    // ---------------- controller: state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_CLEAR;
            clr_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_CLEAR) begin
                clr_q <= clr_q + 1'b1;
            end
        end
    end

    // ---------------- controller: next state ----------------
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_CLEAR: if (clr_q == {IDX_W{1'b1}}) st_d = ST_RUN;
            ST_RUN:   st_d = ST_RUN;
        endcase
    end

    assign pred_ready = (st_q == ST_RUN);

    // ---------------- update path ----------------
    assign upd    = up_valid && pred_ready;
    assign u_lidx = up_addr;
    assign u_gidx = up_addr ^ IDX_W'(up_hist);
    assign u_l    = loc_bits[u_lidx];
    assign u_g    = pat_bits[u_gidx];

    // ---------------- controller: outputs (table write control) ----------------
    always_comb begin
        we_loc = 1'b0;
        we_pat = 1'b0;
        we_sel = 1'b0;
        a_loc  = clr_q;
        a_pat  = clr_q;
        d_loc  = 1'b0;
        d_pat  = 1'b0;
        d_sel  = 1'b0;
        unique case (st_q)
            ST_CLEAR: begin
                we_loc = 1'b1;
                we_pat = 1'b1;
                we_sel = 1'b1;
            end
            ST_RUN: begin
                we_loc = upd;
                a_loc  = u_lidx;
                d_loc  = up_taken;
                we_pat = upd;
                a_pat  = u_gidx;
                d_pat  = up_taken;
                we_sel = upd && (u_l != u_g);
                d_sel  = (u_g == up_taken);
            end
        endcase
    end

    tbp_table #(.IDX_W(IDX_W)) i_loc (
        .clk(clk), .rst_n(rst_n), .we(we_loc), .waddr(a_loc), .wdata(d_loc), .bits_q(loc_bits)
    );
    tbp_table #(.IDX_W(IDX_W)) i_pat (
        .clk(clk), .rst_n(rst_n), .we(we_pat), .waddr(a_pat), .wdata(d_pat), .bits_q(pat_bits)
    );
    tbp_table #(.IDX_W(IDX_W)) i_sel (
        .clk(clk), .rst_n(rst_n), .we(we_sel), .waddr(a_pat), .wdata(d_sel), .bits_q(sel_bits)
    );

    // ---------------- lookup lanes, history chained lane to lane ----------------
    genvar gi;
    generate
        for (gi = 0; gi < LANES; gi++) begin : lane_g
            logic [HIST_W-1:0] h_in;
            logic [HIST_W-1:0] h_out;
            logic [IDX_W-1:0]  lidx, gidx;
            logic              l_bit, g_bit, s_bit, act, pred;

            if (gi == 0) begin : first_g
                assign h_in = spec_q;
            end else begin : chain_g
                assign h_in = lane_g[gi-1].h_out;
            end

            assign lidx  = lk_addr[gi*IDX_W +: IDX_W];
            assign gidx  = lidx ^ IDX_W'(h_in);
            assign l_bit = loc_bits[lidx];
            assign g_bit = pat_bits[gidx];
            assign s_bit = sel_bits[gidx];
            assign act   = lk_valid[gi] && pred_ready;
            assign pred  = act && (s_bit ? g_bit : l_bit);
            assign h_out = act ? {h_in[HIST_W-2:0], pred} : h_in;

            assign lk_taken[gi]                   = pred;
            assign lk_hist[gi*HIST_W +: HIST_W]   = h_in;

            // R4
            agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (act && (l_bit == g_bit)) |-> (lk_taken[gi] == l_bit));
        end
    endgenerate

    assign spec_shift   = lane_g[LANES-1].h_out;
    assign spec_restore = {up_hist[HIST_W-2:0], up_taken};

    tbp_hist #(.HIST_W(HIST_W)) i_hist (
        .clk(clk), .rst_n(rst_n), .restore(upd && up_mispred),
        .restore_val(spec_restore), .shift_val(spec_shift), .hist_q(spec_q)
    );

    // ---------------- assertions ----------------
    // R1
    rdy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pred_ready |=> pred_ready);

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_ready |-> (lk_taken == '0));

    // R8
    restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_ready && up_valid && up_mispred) |=>
        (lk_hist[HIST_W-1:0] == {$past(up_hist[HIST_W-2:0]), $past(up_taken)}));

    // R6
    sel_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_ready && up_valid && (u_l == u_g)) |=>
        (sel_bits[$past(u_gidx)] == $past(sel_bits[u_gidx])));
endmodule

// File: tb/test_tbp_tournament.sv
`timescale 1ns/1ps
module test_tbp_tournament;
    localparam int LN = 2;
    localparam int IW = 4;
    localparam int HW = 4;
    localparam int NE = 1 << IW;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [LN-1:0]     lk_valid = '0;
    logic [LN*IW-1:0]  lk_addr = '0;
    logic [LN-1:0]     lk_taken;
    logic [LN*HW-1:0]  lk_hist;
    logic              up_valid = 1'b0;
    logic [IW-1:0]     up_addr = '0;
    logic [HW-1:0]     up_hist = '0;
    logic              up_taken = 1'b0;
    logic              up_mispred = 1'b0;
    logic              pred_ready;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // bench model of the tables and history
    bit        m_loc [NE];
    bit        m_pat [NE];
    bit        m_sel [NE];
    bit [HW-1:0] m_hist;
    bit        prev_restore;
    string     ptag;
    logic [15:0] lf = 16'hACE1;

    always #10 clk = ~clk;

    tbp_tournament #(.LANES(LN), .IDX_W(IW), .HIST_W(HW)) i_tbp_tournament (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
        .lk_taken(lk_taken), .lk_hist(lk_hist), .up_valid(up_valid), .up_addr(up_addr),
        .up_hist(up_hist), .up_taken(up_taken), .up_mispred(up_mispred), .pred_ready(pred_ready)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] nxt(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    // one cycle: entered at a negedge, drives, checks, advances the model, ends at the next negedge
    task automatic step(input bit [LN-1:0] v, input bit [IW-1:0] a0, input bit [IW-1:0] a1,
                        input bit uv, input bit [IW-1:0] ua, input bit [HW-1:0] uh,
                        input bit ut, input bit um);
        bit [HW-1:0] h;
        bit [IW-1:0] li, gx;
        bit p, l, g;
        lk_valid = v; lk_addr = {a1, a0};
        up_valid = uv; up_addr = ua; up_hist = uh; up_taken = ut; up_mispred = um;
        #1;
        h = m_hist;
        for (int i = 0; i < LN; i++) begin
            li = (i == 0) ? a0 : a1;
            gx = li ^ IW'(h);
            p  = m_sel[gx] ? m_pat[gx] : m_loc[li];
            if (v[i]) begin
                chk(lk_taken[i] == p, ptag, int'(lk_taken[i]), int'(p));
                chk(lk_hist[i*HW +: HW] == h, prev_restore ? "R8" : "R7",
                    int'(lk_hist[i*HW +: HW]), int'(h));
                h = {h[HW-2:0], p};
            end else begin
                chk(lk_taken[i] == 1'b0, "R4", int'(lk_taken[i]), 0);
            end
        end
        if (uv) begin
            li = ua;
            gx = ua ^ IW'(uh);
            l = m_loc[li];
            g = m_pat[gx];
            if (l != g) m_sel[gx] = (g == ut);
            m_loc[li] = ut;
            m_pat[gx] = ut;
        end
        if (uv && um) m_hist = {uh[HW-2:0], ut};
        else          m_hist = h;
        prev_restore = uv && um;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        int n;
        for (int i = 0; i < NE; i++) begin m_loc[i] = 0; m_pat[i] = 0; m_sel[i] = 0; end
        m_hist = '0;
        prev_restore = 0;
        repeat (3) @(negedge clk);
        chk(pred_ready == 1'b0, "R1", int'(pred_ready), 0);
        rst_n = 1'b1;
        // during the clearing sweep: lookups and updates must have no effect (R2)
        lk_valid = '1; lk_addr = 8'h53;
        up_valid = 1'b1; up_addr = '0; up_hist = 4'hF; up_taken = 1'b1; up_mispred = 1'b1;
        n = 0;
        while (n < 100) begin
            @(posedge clk);
            @(negedge clk);
            n++;
            if (pred_ready) break;
            chk(lk_taken == '0, "R2", int'(lk_taken), 0);
        end
        lk_valid = '0; up_valid = 1'b0; up_mispred = 1'b0;
        #1;
        chk(n == NE, "R1", n, NE);
        chk(lk_hist[HW-1:0] == '0, "R2", int'(lk_hist[HW-1:0]), 0);
        @(negedge clk);
        chk(pred_ready == 1'b1, "R1", int'(pred_ready), 1);

        // R3: untouched tables predict not-taken everywhere
        ptag = "R3";
        for (int i = 0; i < NE; i++) step(2'b11, IW'(i), IW'(i + 7), 0, '0, '0, 0, 0);

        // R5: agreeing training, then read back
        ptag = "R5";
        for (int i = 0; i < NE; i++) step(2'b00, '0, '0, 1, IW'(i), '0, i[0] ^ i[2], 0);
        for (int i = 0; i < NE; i++) step(2'b01, IW'(i), '0, 0, '0, '0, 0, 0);

        // R6: random updates without restore create table disagreements
        ptag = "R6";
        for (int k = 0; k < 600; k++) begin
            lf = nxt(lf);
            step(lf[1:0], lf[5:2], lf[9:6], lf[10], lf[14:11], {lf[15], lf[3:1]}, lf[7], 0);
        end

        // R4 / R7 / R8: random traffic including mispredict restores
        ptag = "R4";
        for (int k = 0; k < 1200; k++) begin
            lf = nxt(lf);
            step(lf[1:0], lf[5:2], lf[9:6], lf[10] | lf[0], lf[14:11], {lf[2], lf[15], lf[8], lf[4]},
                 lf[7], lf[12] & lf[3]);
        end

        // R9: update aimed at the entries lane 0 reads in the same cycle
        ptag = "R9";
        for (int k = 0; k < 64; k++) begin
            bit [IW-1:0] a;
            bit [IW-1:0] gx;
            bit p;
            lf = nxt(lf);
            a  = lf[3:0];
            gx = a ^ IW'(m_hist);
            p  = m_sel[gx] ? m_pat[gx] : m_loc[a];
            step(2'b01, a, '0, 1, a, m_hist, ~p, lf[9]);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule